// File: doc/BRIEF.md
# Indirect Timing-Register Access Bridge

This block gives a host access to a large space of per-port and global timing registers using only two host-visible registers: a command register and a data register. The host writes a command word that names an operation, a target (a physical port or one of two global banks), a sub-block selector and a 5-bit register address. The bridge then carries out the access on a simple synchronous register-file port. The access is one of three kinds: a single write, a single read, or a snapshot read of several consecutive registers. While an access is in flight, the top bit of the command register reads as 1.

For a write, the host loads the data register first and then issues the command. For reads, the host polls the busy bit, then pulls words out of the data register one read at a time. A snapshot read takes all of its words from the target in back-to-back cycles, so a multi-word quantity such as a timestamp cannot tear while the host drains it. A parameter selects one of two command-word layouts. The layouts differ in opcode width, opcode values, port-field width and the codes used for the two global banks.

Top module: `timing_reg_bridge`

## Requirements
- R1: After reset the command register reads 16'h0000. When a command is accepted, bit 15 of the command read-back is 1 in the following cycle. Bit 15 returns to 0 when the access completes, and bits 14:0 keep the accepted command.
- R2: With LAYOUT=0 the opcode is bits 14:12: 3'b100 is a single read, 3'b110 is a snapshot read and 3'b011 is a write. The port is bits 11:8, and the global bank codes are 4'hE and 4'hF.
- R3: With LAYOUT=1 the opcode is bits 14:13: 2'b00 is a single read, 2'b10 is a snapshot read and 2'b11 is a write. The port is bits 12:8, and the global bank codes are 5'h1E and 5'h1F.
- R4: Command bits 7:5 are driven on the target sub-block output and bits 4:0 on the target address. The port field, zero-extended to 5 bits, is driven on the target port.
- R5: A global bank code is accepted and forwarded like a physical port, even when it is numerically at or above NUM_PORTS.
- R6: A snapshot read makes SNAP_DEPTH (4) target reads in consecutive cycles, at addresses base, base+1, … wrapping modulo 32. Successive data-register reads return the words in that ascending order.
- R7: Data-register reads past the last valid word (the 4th word of a snapshot, or the only word of a single read) return that last word again.
- R8: A host write to the data register makes that word readable from the data register. A write command then performs exactly one target write carrying that word.
- R9: A single read makes exactly one target read, and its word is returned by the next data-register read.
- R10: While busy, host writes to the command register and the data register are ignored. The command read-back is unchanged, and the running access completes as first issued.
- R11: An unused opcode, or a port value that is neither below NUM_PORTS nor a global bank code, makes no target access. Busy is still set for one cycle and then clears.
- R12: The target returns read data one cycle after the read is presented. Target valid is asserted only while busy is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe; a data-register read advances the drain pointer |
| host_sel | input | 1 | Register select: 0 is the command register, 1 is the data register |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read-back of the selected register (combinational) |
| tgt_valid | output | 1 | Target access strobe |
| tgt_we | output | 1 | Target write enable |
| tgt_port | output | 5 | Target port or global bank code |
| tgt_blk | output | 3 | Target sub-block selector |
| tgt_addr | output | 5 | Target register address |
| tgt_wdata | output | 16 | Target write data |
| tgt_rdata | input | 16 | Target read data, one cycle after the read |

## Verification
The hardest state to reach from the ports is a command arriving while a snapshot read is still issuing. The host would normally poll busy first and never try this. The bench forces it by issuing a second command on the cycle right after a snapshot command is accepted. It then checks that the command read-back and the drained words still belong to the first command. Address wrap across register 31 and a global bank code above the physical port range are reached through dedicated table entries. Both layouts are instantiated side by side, so the opcode decodes that clash between them are exercised together.

// File: rtl/timing_bridge_pkg.sv
package timing_bridge_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 5;
    localparam int PORT_W = 5;
    localparam int BLK_W  = 3;

    // Layout 0 opcode and bank codes
    localparam logic [2:0] L0_OP_RD    = 3'b100;
    localparam logic [2:0] L0_OP_RDINC = 3'b110;
    localparam logic [2:0] L0_OP_WR    = 3'b011;
    localparam logic [3:0] L0_BANK_TIME = 4'hE;
    localparam logic [3:0] L0_BANK_PTP  = 4'hF;

    // Layout 1 opcode and bank codes
    localparam logic [1:0] L1_OP_RD    = 2'b00;
    localparam logic [1:0] L1_OP_RDINC = 2'b10;
    localparam logic [1:0] L1_OP_WR    = 2'b11;
    localparam logic [4:0] L1_BANK_TIME = 5'h1E;
    localparam logic [4:0] L1_BANK_PTP  = 5'h1F;

    typedef enum logic [1:0] {
        OPK_READ  = 2'd0,
        OPK_RDINC = 2'd1,
        OPK_WRITE = 2'd2,
        OPK_BAD   = 2'd3
    } op_kind_t;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2,
        S_DONE  = 2'd3
    } seq_state_t;

    typedef struct packed {
        op_kind_t          op;
        logic [PORT_W-1:0] port;
        logic [BLK_W-1:0]  blk;
        logic [ADDR_W-1:0] addr;
        logic              legal;
    } cmd_fields_t;

    function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] base,
                                                     input logic [ADDR_W-1:0] ofs);
        return base + ofs;
    endfunction

endpackage

// File: rtl/tbr_cmd_decode.sv
module tbr_cmd_decode
    import timing_bridge_pkg::*;
#(
    parameter int LAYOUT    = 0,
    parameter int NUM_PORTS = 7
) (
    input  logic [DATA_W-1:0] cmd_word,
    output cmd_fields_t       fields
);

    localparam logic [PORT_W-1:0] PORT_LIM = PORT_W'(NUM_PORTS);

    op_kind_t          op_k;
    logic [PORT_W-1:0] port_v;
    logic              is_bank;

    generate
        if (LAYOUT == 0) begin : g_layout0
            always_comb begin
                unique case (cmd_word[14:12])
                    L0_OP_RD:    op_k = OPK_READ;
                    L0_OP_RDINC: op_k = OPK_RDINC;
                    L0_OP_WR:    op_k = OPK_WRITE;
                    default:     op_k = OPK_BAD;
                endcase
                port_v  = {1'b0, cmd_word[11:8]};
                is_bank = (cmd_word[11:8] == L0_BANK_TIME) ||
                          (cmd_word[11:8] == L0_BANK_PTP);
            end
        end else begin : g_layout1
            always_comb begin
                unique case (cmd_word[14:13])
                    L1_OP_RD:    op_k = OPK_READ;
                    L1_OP_RDINC: op_k = OPK_RDINC;
                    L1_OP_WR:    op_k = OPK_WRITE;
                    default:     op_k = OPK_BAD;
                endcase
                port_v  = cmd_word[12:8];
                is_bank = (cmd_word[12:8] == L1_BANK_TIME) ||
                          (cmd_word[12:8] == L1_BANK_PTP);
            end
        end
    endgenerate

    always_comb begin
        fields.op    = op_k;
        fields.port  = port_v;
        fields.blk   = cmd_word[7:5];
        fields.addr  = cmd_word[4:0];
        fields.legal = (op_k != OPK_BAD) && (is_bank || (port_v < PORT_LIM));
    end

endmodule

// File: rtl/tbr_snapshot.sv
module tbr_snapshot
    import timing_bridge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load_host,
    input  logic [DATA_W-1:0]           host_word,
    input  logic                        arm,
    input  logic [$clog2(DEPTH+1)-1:0]  arm_cnt,
    input  logic                        cap_en,
    input  logic [$clog2(DEPTH)-1:0]    cap_idx,
    input  logic [DATA_W-1:0]           cap_word,
    input  logic                        pop,
    output logic [DATA_W-1:0]           out_word
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [DATA_W-1:0] words [DEPTH];
    logic [PTR_W-1:0]  ptr;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  ptr_next_ext;

    assign ptr_next_ext = CNT_W'(ptr) + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= '0;
            end
            ptr <= '0;
            cnt <= CNT_W'(1);
        end else begin
            if (cap_en) begin
                words[cap_idx] <= cap_word;
            end
            if (load_host) begin
                words[0] <= host_word;
                ptr      <= '0;
                cnt      <= CNT_W'(1);
            end else if (arm) begin
                ptr <= '0;
                cnt <= arm_cnt;
            end else if (pop && (ptr_next_ext < cnt)) begin
                ptr <= ptr + PTR_W'(1);
            end
        end
    end

    assign out_word = words[ptr];

endmodule

// File: rtl/tbr_access_seq.sv
module tbr_access_seq
    import timing_bridge_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        start,
    input  cmd_fields_t                 fld,
    input  logic [DATA_W-1:0]           wr_word,
    input  logic [DATA_W-1:0]           tgt_rdata,
    output logic                        busy,
    output logic                        tgt_valid,
    output logic                        tgt_we,
    output logic [PORT_W-1:0]           tgt_port,
    output logic [BLK_W-1:0]            tgt_blk,
    output logic [ADDR_W-1:0]           tgt_addr,
    output logic [DATA_W-1:0]           tgt_wdata,
    output logic                        arm,
    output logic [$clog2(DEPTH+1)-1:0]  arm_cnt,
    output logic                        cap_en,
    output logic [$clog2(DEPTH)-1:0]    cap_idx,
    output logic [DATA_W-1:0]           cap_word
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH-1);

    seq_state_t        state;
    cmd_fields_t       f_q;
    logic [PTR_W-1:0]  idx;
    logic [PTR_W-1:0]  last_q;
    logic              pend_q;
    logic [PTR_W-1:0]  pidx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            f_q    <= '0;
            idx    <= '0;
            last_q <= '0;
            pend_q <= 1'b0;
            pidx_q <= '0;
        end else begin
            pend_q <= tgt_valid && !tgt_we;
            pidx_q <= idx;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        f_q    <= fld;
                        idx    <= '0;
                        last_q <= (fld.op == OPK_RDINC) ? LAST_IDX : '0;
                        state  <= fld.legal ? S_ISSUE : S_DONE;
                    end
                end
                S_ISSUE: begin
                    if (f_q.op == OPK_WRITE) begin
                        state <= S_IDLE;
                    end else if (idx == last_q) begin
                        state <= S_WAIT;
                    end else begin
                        idx <= idx + PTR_W'(1);
                    end
                end
                S_WAIT:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy      = (state != S_IDLE);
    assign tgt_valid = (state == S_ISSUE);
    assign tgt_we    = (state == S_ISSUE) && (f_q.op == OPK_WRITE);
    assign tgt_port  = f_q.port;
    assign tgt_blk   = f_q.blk;
    assign tgt_addr  = step_addr(f_q.addr, ADDR_W'(idx));
    assign tgt_wdata = wr_word;

    assign arm     = start && fld.legal && (fld.op != OPK_WRITE);
    assign arm_cnt = (fld.op == OPK_RDINC) ? CNT_W'(DEPTH) : CNT_W'(1);

    assign cap_en   = pend_q;
    assign cap_idx  = pidx_q;
    assign cap_word = tgt_rdata;

endmodule

// File: rtl/timing_reg_bridge.sv
module timing_reg_bridge
    import timing_bridge_pkg::*;
#(
    parameter int LAYOUT     = 0,
    parameter int NUM_PORTS  = 7,
    parameter int SNAP_DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        host_wr,
    input  logic        host_rd,
    input  logic        host_sel,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        tgt_valid,
    output logic        tgt_we,
    output logic [4:0]  tgt_port,
    output logic [2:0]  tgt_blk,
    output logic [4:0]  tgt_addr,
    output logic [15:0] tgt_wdata,
    input  logic [15:0] tgt_rdata
);

    localparam int PTR_W = $clog2(SNAP_DEPTH);
    localparam int CNT_W = $clog2(SNAP_DEPTH+1);

    logic              busy;
    logic [14:0]       cmd_q;
    logic              cmd_wr;
    logic              data_wr;
    logic              data_rd;
    cmd_fields_t       fields;
    logic [DATA_W-1:0] data_word;
    logic              arm;
    logic [CNT_W-1:0]  arm_cnt;
    logic              cap_en;
    logic [PTR_W-1:0]  cap_idx;
    logic [DATA_W-1:0] cap_word;

    assign cmd_wr  = host_wr && !host_sel && !busy;
    assign data_wr = host_wr &&  host_sel && !busy;
    assign data_rd = host_rd &&  host_sel && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else if (cmd_wr) begin
            cmd_q <= host_wdata[14:0];
        end
    end

    tbr_cmd_decode #(
        .LAYOUT    (LAYOUT),
        .NUM_PORTS (NUM_PORTS)
    ) u_decode (
        .cmd_word (host_wdata),
        .fields   (fields)
    );

    tbr_access_seq #(
        .DEPTH (SNAP_DEPTH)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (cmd_wr),
        .fld       (fields),
        .wr_word   (data_word),
        .tgt_rdata (tgt_rdata),
        .busy      (busy),
        .tgt_valid (tgt_valid),
        .tgt_we    (tgt_we),
        .tgt_port  (tgt_port),
        .tgt_blk   (tgt_blk),
        .tgt_addr  (tgt_addr),
        .tgt_wdata (tgt_wdata),
        .arm       (arm),
        .arm_cnt   (arm_cnt),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .cap_word  (cap_word)
    );

    tbr_snapshot #(
        .DEPTH (SNAP_DEPTH)
    ) u_snap (
        .clk       (clk),
        .rst       (rst),
        .load_host (data_wr),
        .host_word (host_wdata),
        .arm       (arm),
        .arm_cnt   (arm_cnt),
        .cap_en    (cap_en),
        .cap_idx   (cap_idx),
        .cap_word  (cap_word),
        .pop       (data_rd),
        .out_word  (data_word)
    );

    assign host_rdata = host_sel ? data_word : {busy, cmd_q};

endmodule

// File: rtl/tbr_checker.sv
module tbr_checker #(
    parameter int LAYOUT    = 0,
    parameter int NUM_PORTS = 7
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic [14:0] cmd_q,
    input logic        host_wr,
    input logic        host_sel,
    input logic        tgt_valid,
    input logic        tgt_we,
    input logic [4:0]  tgt_port,
    input logic [4:0]  tgt_addr
);

    localparam logic [4:0] PORT_LIM = 5'(NUM_PORTS);
    localparam logic [4:0] BANK_T   = (LAYOUT == 0) ? 5'h0E : 5'h1E;
    localparam logic [4:0] BANK_P   = (LAYOUT == 0) ? 5'h0F : 5'h1F;

    // R12: target is only touched while busy
    a_r12_valid_in_busy: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> busy);

    // R1: an accepted command raises busy on the next cycle
    a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_sel && !busy) |=> busy);

    // R10: command register holds while busy
    a_r10_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && host_wr && !host_sel) |=> $stable(cmd_q));

    // R6: back-to-back snapshot reads step the address by one on one port
    a_r6_ascending: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && !tgt_we && $past(tgt_valid && !tgt_we)) |->
        ((tgt_addr == $past(tgt_addr) + 5'd1) && (tgt_port == $past(tgt_port))));

    // R8: a write is a single target access
    a_r8_single_write: assert property (@(posedge clk) disable iff (rst)
        (tgt_valid && tgt_we) |=> !tgt_valid);

    // R11: only legal ports reach the target
    a_r11_legal_port: assert property (@(posedge clk) disable iff (rst)
        tgt_valid |-> ((tgt_port < PORT_LIM) || (tgt_port == BANK_T) || (tgt_port == BANK_P)));

endmodule

bind timing_reg_bridge tbr_checker #(
    .LAYOUT    (LAYOUT),
    .NUM_PORTS (NUM_PORTS)
) u_tbr_checker (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .cmd_q     (cmd_q),
    .host_wr   (host_wr),
    .host_sel  (host_sel),
    .tgt_valid (tgt_valid),
    .tgt_we    (tgt_we),
    .tgt_port  (tgt_port),
    .tgt_addr  (tgt_addr)
);

// File: tb/tb_timing_reg_bridge.sv
module tb_target_model (
    input  logic        clk,
    input  logic        valid,
    input  logic        we,
    input  logic [4:0]  port,
    input  logic [2:0]  blk,
    input  logic [4:0]  addr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output int          n_acc,
    output logic [12:0] last_key,
    output logic [15:0] last_data
);
    initial begin
        n_acc     = 0;
        rdata     = '0;
        last_key  = '0;
        last_data = '0;
    end
    always @(posedge clk) begin
        if (valid) begin
            n_acc <= n_acc + 1;
            if (we) begin
                last_key  <= {port, blk, addr};
                last_data <= wdata;
            end else begin
                rdata <= {blk, port, addr, 3'b110};
            end
        end
    end
endmodule

module tb_timing_reg_bridge;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        h_wr = 1'b0;
    logic        h_rd = 1'b0;
    logic        h_sel = 1'b0;
    logic [15:0] h_wd = '0;

    logic [15:0] rd_a, rd_b;
    logic        va, wea, vb, web;
    logic [4:0]  pa, aa, pb, ab;
    logic [2:0]  ba, bb;
    logic [15:0] wda, wdb, tra, trb;
    int          acc_a, acc_b;
    logic [12:0] key_a, key_b;
    logic [15:0] ld_a, ld_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    timing_reg_bridge #(.LAYOUT(0), .NUM_PORTS(7)) dut (
        .clk(clk), .rst(rst), .host_wr(h_wr), .host_rd(h_rd), .host_sel(h_sel),
        .host_wdata(h_wd), .host_rdata(rd_a), .tgt_valid(va), .tgt_we(wea),
        .tgt_port(pa), .tgt_blk(ba), .tgt_addr(aa), .tgt_wdata(wda), .tgt_rdata(tra));

    timing_reg_bridge #(.LAYOUT(1), .NUM_PORTS(7)) dut_b (
        .clk(clk), .rst(rst), .host_wr(h_wr), .host_rd(h_rd), .host_sel(h_sel),
        .host_wdata(h_wd), .host_rdata(rd_b), .tgt_valid(vb), .tgt_we(web),
        .tgt_port(pb), .tgt_blk(bb), .tgt_addr(ab), .tgt_wdata(wdb), .tgt_rdata(trb));

    tb_target_model m_a (.clk(clk), .valid(va), .we(wea), .port(pa), .blk(ba), .addr(aa),
        .wdata(wda), .rdata(tra), .n_acc(acc_a), .last_key(key_a), .last_data(ld_a));
    tb_target_model m_b (.clk(clk), .valid(vb), .we(web), .port(pb), .blk(bb), .addr(ab),
        .wdata(wdb), .rdata(trb), .n_acc(acc_b), .last_key(key_b), .last_data(ld_b));

    function automatic logic [15:0] tv(input logic [4:0] p, input logic [2:0] b, input logic [4:0] a);
        return {b, p, a, 3'b110};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic host_cmd(input logic [15:0] w);
        @(negedge clk);
        h_wr = 1'b1; h_sel = 1'b0; h_wd = w;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic host_dwrite(input logic [15:0] w);
        @(negedge clk);
        h_wr = 1'b1; h_sel = 1'b1; h_wd = w;
        @(negedge clk);
        h_wr = 1'b0; h_sel = 1'b0;
    endtask

    task automatic host_dread(input int which, output logic [15:0] v);
        @(negedge clk);
        h_sel = 1'b1; h_rd = 1'b1;
        #1;
        v = (which == 0) ? rd_a : rd_b;
        @(negedge clk);
        h_rd = 1'b0; h_sel = 1'b0;
    endtask

    task automatic cmd_view(input int which, output logic [15:0] v);
        h_sel = 1'b0;
        #1;
        v = (which == 0) ? rd_a : rd_b;
    endtask

    task automatic wait_idle(input int which);
        logic [15:0] v;
        for (int k = 0; k < 50; k++) begin
            cmd_view(which, v);
            if (!v[15]) break;
            @(negedge clk);
        end
    endtask

    // {command, word count}
    localparam logic [18:0] VEC [5] = '{
        {16'h4325, 3'd1},   // single read, port 3, blk 1, addr 5
        {16'h6F1E, 3'd4},   // snapshot, PTP bank, addr 30 wraps
        {16'h6062, 3'd4},   // snapshot, port 0, blk 3, addr 2
        {16'h4E5F, 3'd1},   // single read, time bank, blk 2, addr 31
        {16'h4600, 3'd1}    // single read, highest port 6
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int a0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        cmd_view(0, v);
        check("R1 reset cmd", 32'(v), 32'h0);
        check("R12 reset valid", 32'(va), 32'h0);

        // R2 R4 R5 R6 R7 R9: table of layout-0 reads
        for (int i = 0; i < 5; i++) begin
            logic [15:0] c;
            int n;
            c = VEC[i][18:3];
            n = int'(VEC[i][2:0]);
            a0 = acc_a;
            host_cmd(c);
            cmd_view(0, v);
            check("R1 busy set", 32'(v[15]), 32'h1);
            wait_idle(0);
            cmd_view(0, v);
            check("R1 cmd readback", 32'(v), 32'({1'b0, c[14:0]}));
            check("R9 R6 access count", 32'(acc_a - a0), 32'(n));
            for (int k = 0; k < n; k++) begin
                host_dread(0, v);
                check("R6 R2 R4 word", 32'(v), 32'(tv({1'b0, c[11:8]}, c[7:5], c[4:0] + 5'(k))));
            end
            host_dread(0, v);
            check("R7 over-read", 32'(v), 32'(tv({1'b0, c[11:8]}, c[7:5], c[4:0] + 5'(n - 1))));
        end

        // R8: data register and write command
        host_dwrite(16'hBEEF);
        host_dread(0, v);
        check("R8 data readback", 32'(v), 32'hBEEF);
        a0 = acc_a;
        host_cmd(16'h3227);
        wait_idle(0);
        check("R8 write count", 32'(acc_a - a0), 32'd1);
        check("R8 write key", 32'(key_a), 32'({5'd2, 3'd1, 5'd7}));
        check("R8 write data", 32'(ld_a), 32'hBEEF);

        // R11: unused opcode
        a0 = acc_a;
        host_cmd(16'h0325);
        cmd_view(0, v);
        check("R11 busy pulse", 32'(v[15]), 32'h1);
        @(negedge clk);
        cmd_view(0, v);
        check("R11 busy cleared", 32'(v[15]), 32'h0);
        check("R11 no access op", 32'(acc_a - a0), 32'd0);

        // R11: port 9 is not physical and not a bank
        a0 = acc_a;
        host_cmd(16'h4901);
        wait_idle(0);
        check("R11 no access port", 32'(acc_a - a0), 32'd0);

        // R10: command and data writes while busy are ignored
        a0 = acc_a;
        host_cmd(16'h6F1E);
        host_cmd(16'h4325);
        host_dwrite(16'h1234);
        wait_idle(0);
        cmd_view(0, v);
        check("R10 cmd unchanged", 32'(v), 32'h6F1E);
        check("R10 access count", 32'(acc_a - a0), 32'd4);
        host_dread(0, v);
        check("R10 first word kept", 32'(v), 32'(tv(5'h0F, 3'd0, 5'd30)));

        // R3: layout 1
        repeat (8) @(negedge clk);
        a0 = acc_b;
        host_cmd(16'h5F03);
        wait_idle(1);
        check("R3 snapshot count", 32'(acc_b - a0), 32'd4);
        for (int k = 0; k < 4; k++) begin
            host_dread(1, v);
            check("R3 R5 snapshot word", 32'(v), 32'(tv(5'h1F, 3'd0, 5'(3 + k))));
        end
        host_cmd(16'h1E29);
        wait_idle(1);
        host_dread(1, v);
        check("R3 single read", 32'(v), 32'(tv(5'h1E, 3'd1, 5'd9)));
        host_dwrite(16'hA55A);
        host_cmd(16'h6441);
        wait_idle(1);
        check("R3 write key", 32'(key_b), 32'({5'd4, 3'd2, 5'd1}));
        check("R3 write data", 32'(ld_b), 32'hA55A);
        a0 = acc_b;
        host_cmd(16'h2201);
        wait_idle(1);
        check("R11 R3 unused op", 32'(acc_b - a0), 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule